// File: doc/BRIEF.md
# AUX-I2C Request Frame Generator

This block sits on the source side of a display auxiliary channel and turns three register writes into I2C-over-AUX request frames. Software loads a device address register and, for writes, pushes payload bytes into a small FIFO. A write to the command register then launches one request. The block builds a three-byte header from a 4-bit command nibble and a 20-bit address. Depending on the command, it adds a length byte and the payload bytes. The frame leaves one byte per handshake on a valid/ready stream that is flagged with a last marker.

After the final byte, the block waits for the reply stream. The first reply byte carries the reply code, and any later bytes are forwarded as read data. When the reply ends, busy drops, the code is latched and a one-cycle done pulse is raised. A single flag in the command register turns a read or write into a header-only request. Write-status commands are always header-only. One command write can therefore yield three frame shapes. A DEFER reply leaves the payload in the FIFO, so reissuing the same command resends the same bytes.

Top module: `aux_i2c_req_gen`

## Requirements
- R1: A write command (nibble 0x0 or 0x4, bit 12 clear) produces the header {nibble, addr[19:16]}, addr[15:8], addr[7:0]. The header is followed by a length byte equal to command bits [3:0], which is the byte count minus one, and then that many plus one payload bytes taken from the FIFO oldest first. tx_last marks the final byte.
- R2: A read command (nibble 0x1 or 0x5, bit 12 clear) produces the three header bytes and the length byte, with tx_last on the length byte and no payload.
- R3: A read or write command with command bit 12 set produces only the three header bytes, with tx_last on the third byte.
- R4: A write-status command (nibble 0x2 or 0x6) produces only the three header bytes, whether or not bit 12 is set and whatever bits [3:0] hold.
- R5: The middle-of-transaction flag, nibble bit 2, appears unchanged in bits [7:4] of the first header byte.
- R6: A command write at offset 0x100 sets busy in the following cycle. Command writes made while busy are ignored. Nibbles with bit 3 set, or with low bits 2'b11, start nothing.
- R7: The first reply byte gives the code in bits [1:0] (0 ACK, 1 NACK, 2 DEFER). Each later reply byte appears once on rd_valid/rd_data. The cycle after the byte flagged rx_last, busy is low, reply_done is high for one cycle and reply_code holds the code.
- R8: After a DEFER reply the payload bytes of that write stay queued, so the same command resends them. After ACK or NACK they are removed.
- R9: The FIFO holds 16 bytes. A push at offset 0x104 while it is full is dropped, and payload bytes missing from the FIFO go out as 0x00.
- R10: Offset 0x108 loads the 20-bit address from data bits [19:0]. A frame uses the address held when its command was accepted.
- R11: While tx_valid is high and tx_ready low, tx_valid, tx_data and tx_last hold in the next cycle.
- R12: After reset, busy, tx_valid, rd_valid and reply_done are low and reply_code is 0.
- R13: Reply bytes that arrive while no request is waiting cause no rd_valid and no reply_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| tx_valid | output | 1 | Request byte valid |
| tx_ready | input | 1 | Request byte accepted |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final byte of the request |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Final reply byte |
| busy | output | 1 | Request in flight |
| reply_done | output | 1 | One-cycle pulse when a reply completes |
| reply_code | output | 2 | Latched reply code |
| rd_valid | output | 1 | Reply data byte valid |
| rd_data | output | 8 | Reply data byte |

## Verification
The bench drives one command nibble through all three frame shapes and checks that the write-status length bits and the header-only flag really cut the frame short. A design that got this wrong would emit a stray length byte or payload. A DEFER followed by a reissue must replay the same payload, while an ACK must move on to new bytes. A design that drains the FIFO on the first send would resend the wrong data. The bench also fills the FIFO past 16 entries and issues commands while busy or with unsupported nibbles. A wrong design would keep the overflow byte, start a second frame or raise busy without cause. Backpressure on tx_ready checks that a stalled byte holds steady.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;

    localparam int REG_AW_DEF = 12;
    localparam int OFS_CMD    = 'h100;
    localparam int OFS_WDATA  = 'h104;
    localparam int OFS_DADDR  = 'h108;
    localparam int AUX_AW     = 20;
    localparam int HDR_BYTES  = 3;
    localparam int LEN_W      = 4;

    typedef enum logic [1:0] {
        SHP_HDR_ONLY = 2'd0,
        SHP_READ     = 2'd1,
        SHP_WRITE    = 2'd2
    } shape_e;

    typedef enum logic [1:0] {
        RPL_ACK   = 2'd0,
        RPL_NACK  = 2'd1,
        RPL_DEFER = 2'd2,
        RPL_RSVD  = 2'd3
    } rpl_e;

    typedef enum logic [2:0] {
        F_IDLE, F_HDR, F_LEN, F_DATA, F_WAIT
    } fstate_e;

    typedef struct packed {
        logic [3:0]       nib;
        shape_e           shape;
        logic [LEN_W-1:0] len;
    } req_t;

    function automatic logic cmd_supported(input logic [3:0] nib);
        return (nib[3] == 1'b0) && (nib[1:0] != 2'b11);
    endfunction

    function automatic shape_e pick_shape(input logic [3:0] nib, input logic hdr_only);
        if (nib[1:0] == 2'b10 || hdr_only) return SHP_HDR_ONLY;
        if (nib[1:0] == 2'b01)             return SHP_READ;
        return SHP_WRITE;
    endfunction

endpackage

// File: rtl/aux_req_regs.sv
module aux_req_regs
    import aux_req_pkg::*;
#(
    parameter int REG_AW = REG_AW_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    output logic              start,
    output req_t              start_req,
    output logic [AUX_AW-1:0] dev_addr,
    output logic              push,
    output logic [7:0]        push_data
);
    logic       sel_cmd;
    logic [3:0] nib;
    logic       unused_bits;

    assign nib     = reg_wdata[11:8];
    assign sel_cmd = reg_wr_en && (reg_addr == REG_AW'(OFS_CMD));
    assign start   = sel_cmd && !busy && cmd_supported(nib);

    always_comb begin
        start_req.nib   = nib;
        start_req.shape = pick_shape(nib, reg_wdata[12]);
        start_req.len   = reg_wdata[LEN_W-1:0];
    end

    assign push      = reg_wr_en && (reg_addr == REG_AW'(OFS_WDATA));
    assign push_data = reg_wdata[7:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_addr <= '0;
        end else if (reg_wr_en && (reg_addr == REG_AW'(OFS_DADDR))) begin
            dev_addr <= reg_wdata[AUX_AW-1:0];
        end
    end

    assign unused_bits = ^{reg_wdata[31:AUX_AW], reg_wdata[7:LEN_W]};

endmodule

// File: rtl/aux_wr_fifo.sv
module aux_wr_fifo #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop,
    input  logic       commit,
    input  logic       rewind,
    output logic [7:0] head,
    output logic       empty
);
    localparam int PW = $clog2(DEPTH);

    logic [7:0]  mem [DEPTH];
    logic [PW:0] wr_ptr, rd_ptr, base_ptr;
    logic [PW:0] held;
    logic        full;

    assign held  = wr_ptr - base_ptr;
    assign full  = (held == (PW+1)'(DEPTH));
    assign empty = (rd_ptr == wr_ptr);
    assign head  = mem[rd_ptr[PW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wr_ptr[PW-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            base_ptr <= '0;
        end else begin
            if (push && !full) wr_ptr <= wr_ptr + 1'b1;
            if (rewind) begin
                rd_ptr <= base_ptr;
            end else if (pop && !empty) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (commit) base_ptr <= rd_ptr;
        end
    end

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
    import aux_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  req_t              start_req,
    input  logic [AUX_AW-1:0] start_addr,
    input  logic [7:0]        fifo_data,
    input  logic              fifo_empty,
    input  logic              tx_ready,
    input  logic              rpl_end,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              pop,
    output logic              waiting,
    output logic              busy
);
    fstate_e           state;
    req_t              cur;
    logic [AUX_AW-1:0] cur_addr;
    logic [1:0]        hdr_idx;
    logic [LEN_W-1:0]  cnt;
    logic              fire;
    logic              hdr_end;

    assign tx_valid = (state == F_HDR) || (state == F_LEN) || (state == F_DATA);
    assign fire     = tx_valid && tx_ready;
    assign hdr_end  = (hdr_idx == 2'(HDR_BYTES-1));
    assign pop      = (state == F_DATA) && tx_ready && !fifo_empty;
    assign waiting  = (state == F_WAIT);
    assign busy     = (state != F_IDLE);

    always_comb begin
        tx_data = 8'h00;
        tx_last = 1'b0;
        case (state)
            F_HDR: begin
                case (hdr_idx)
                    2'd0:    tx_data = {cur.nib, cur_addr[19:16]};
                    2'd1:    tx_data = cur_addr[15:8];
                    default: tx_data = cur_addr[7:0];
                endcase
                tx_last = hdr_end && (cur.shape == SHP_HDR_ONLY);
            end
            F_LEN: begin
                tx_data = 8'(cur.len);
                tx_last = (cur.shape == SHP_READ);
            end
            F_DATA: begin
                tx_data = fifo_empty ? 8'h00 : fifo_data;
                tx_last = (cnt == cur.len);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= F_IDLE;
            cur      <= '0;
            cur_addr <= '0;
            hdr_idx  <= '0;
            cnt      <= '0;
        end else begin
            case (state)
                F_IDLE: if (start) begin
                    cur      <= start_req;
                    cur_addr <= start_addr;
                    hdr_idx  <= '0;
                    state    <= F_HDR;
                end
                F_HDR: if (fire) begin
                    if (hdr_end) begin
                        state <= (cur.shape == SHP_HDR_ONLY) ? F_WAIT : F_LEN;
                    end else begin
                        hdr_idx <= hdr_idx + 2'd1;
                    end
                end
                F_LEN: if (fire) begin
                    cnt   <= '0;
                    state <= (cur.shape == SHP_WRITE) ? F_DATA : F_WAIT;
                end
                F_DATA: if (fire) begin
                    if (cnt == cur.len) state <= F_WAIT;
                    else                cnt   <= cnt + 1'b1;
                end
                F_WAIT: if (rpl_end) state <= F_IDLE;
                default: state <= F_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/aux_reply_cap.sv
module aux_reply_cap
    import aux_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       waiting,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_last,
    output logic       rpl_end,
    output logic       rewind,
    output logic       commit,
    output logic       reply_done,
    output logic [1:0] reply_code,
    output logic       rd_valid,
    output logic [7:0] rd_data
);
    logic       got_code;
    logic [1:0] code_q;
    logic [1:0] code_now;
    logic       accept;

    assign accept   = waiting && rx_valid;
    assign rpl_end  = accept && rx_last;
    assign code_now = got_code ? code_q : rx_data[1:0];
    assign rewind   = rpl_end && (code_now == RPL_DEFER);
    assign commit   = rpl_end && (code_now != RPL_DEFER);

    always_ff @(posedge clk) begin
        if (rst) begin
            got_code   <= 1'b0;
            code_q     <= '0;
            reply_done <= 1'b0;
            reply_code <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            reply_done <= rpl_end;
            rd_valid   <= accept && got_code;
            if (accept) rd_data <= rx_data;
            if (accept && !got_code) code_q <= rx_data[1:0];
            if (rpl_end) begin
                got_code   <= 1'b0;
                reply_code <= code_now;
            end else if (accept) begin
                got_code <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/aux_i2c_req_gen.sv
module aux_i2c_req_gen
    import aux_req_pkg::*;
#(
    parameter int REG_AW = REG_AW_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              busy,
    output logic              reply_done,
    output logic [1:0]        reply_code,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam int FIFO_DEPTH = 1 << LEN_W;

    logic              start;
    req_t              start_req;
    logic [AUX_AW-1:0] dev_addr;
    logic              push;
    logic [7:0]        push_data;
    logic              pop, commit, rewind;
    logic [7:0]        fifo_head;
    logic              fifo_empty;
    logic              waiting;
    logic              rpl_end;

    aux_req_regs #(.REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .busy(busy), .start(start), .start_req(start_req),
        .dev_addr(dev_addr), .push(push), .push_data(push_data)
    );

    aux_wr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(push), .push_data(push_data), .pop(pop),
        .commit(commit), .rewind(rewind),
        .head(fifo_head), .empty(fifo_empty)
    );

    aux_req_framer u_framer (
        .clk(clk), .rst(rst),
        .start(start), .start_req(start_req), .start_addr(dev_addr),
        .fifo_data(fifo_head), .fifo_empty(fifo_empty),
        .tx_ready(tx_ready), .rpl_end(rpl_end),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .pop(pop), .waiting(waiting), .busy(busy)
    );

    aux_reply_cap u_reply (
        .clk(clk), .rst(rst),
        .waiting(waiting), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rpl_end(rpl_end), .rewind(rewind), .commit(commit),
        .reply_done(reply_done), .reply_code(reply_code),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

endmodule

// File: rtl/aux_i2c_req_chk.sv
module aux_i2c_req_chk
    import aux_req_pkg::*;
#(
    parameter int REG_AW = REG_AW_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              busy,
    input logic              reply_done
);
    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_valid_busy_R6: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> busy);

    assert_busy_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wr_en && (reg_addr == REG_AW'(OFS_CMD))));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        reply_done |-> !busy);

    assert_last_valid_R1: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

endmodule

bind aux_i2c_req_gen aux_i2c_req_chk #(.REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .busy(busy), .reply_done(reply_done)
);

// File: tb/tb_aux_i2c_req_gen.sv
module tb_aux_i2c_req_gen;
    import aux_req_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        tx_valid, tx_ready, tx_last;
    logic [7:0]  tx_data;
    logic        rx_valid, rx_last;
    logic [7:0]  rx_data;
    logic        busy, reply_done, rd_valid;
    logic [1:0]  reply_code;
    logic [7:0]  rd_data;

    always #2.5 clk = ~clk;

    aux_i2c_req_gen dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .busy(busy),
        .reply_done(reply_done), .reply_code(reply_code),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int          total = 0;
    int          bad = 0;
    string       cur_req = "R12";
    logic [8:0]  exp_q[$];
    logic [7:0]  rd_q[$];
    logic [7:0]  m_fifo[$];
    logic [19:0] m_addr = '0;
    int          pending = 0;
    int          rcnt = 0;
    logic        prev_stall = 1'b0;
    logic [8:0]  prev_byte = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // backpressure pattern, changed just after the edge
    initial begin
        tx_ready = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            rcnt++;
            tx_ready = (rcnt % 4) != 1;
        end
    end

    // monitor: pops expected bytes and compares
    initial begin
        forever begin : mon
            logic [8:0] e;
            @(negedge clk);
            if (!rst) begin
                if (prev_stall) begin
                    chk(tx_valid && ({tx_last, tx_data} == prev_byte), "R11",
                        "stalled byte changed", {tx_valid, tx_last, tx_data}, {1'b1, prev_byte});
                end
                prev_stall = tx_valid && !tx_ready;
                prev_byte  = {tx_last, tx_data};
                if (tx_valid && tx_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, cur_req, "unexpected tx byte", {tx_last, tx_data}, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk({tx_last, tx_data} == e, cur_req, "tx {last,data}",
                            {tx_last, tx_data}, e);
                    end
                end
                if (rd_valid) begin
                    if (rd_q.size() == 0) begin
                        chk(1'b0, "R7", "unexpected rd byte", rd_data, 0);
                    end else begin
                        e = {1'b0, rd_q.pop_front()};
                        chk(rd_data == e[7:0], "R7", "rd_data", rd_data, e[7:0]);
                    end
                end
            end
        end
    end

    task automatic reg_write(input int ofs, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = 12'(ofs);
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        reg_write(OFS_WDATA, {24'h0, b});
        if (m_fifo.size() < 16) m_fifo.push_back(b);
    endtask

    task automatic set_addr(input logic [19:0] a);
        reg_write(OFS_DADDR, {12'h0, a});
        m_addr = a;
    endtask

    task automatic issue(input logic [3:0] nib, input bit ab, input logic [3:0] len);
        bit hdr_only, is_rd;
        hdr_only = (nib[1:0] == 2'b10) || ab;
        is_rd    = (nib[1:0] == 2'b01);
        exp_q.push_back({1'b0, nib, m_addr[19:16]});
        exp_q.push_back({1'b0, m_addr[15:8]});
        exp_q.push_back({hdr_only, m_addr[7:0]});
        pending = 0;
        if (!hdr_only) begin
            exp_q.push_back({is_rd, 4'h0, len});
            if (!is_rd) begin
                pending = int'(len) + 1;
                for (int i = 0; i <= int'(len); i++) begin
                    exp_q.push_back({(i == int'(len)), (i < m_fifo.size()) ? m_fifo[i] : 8'h00});
                end
            end
        end
        reg_write(OFS_CMD, {19'h0, ab, nib, 4'h0, len});
        chk(busy == 1'b1, "R6", "busy after command", busy, 1);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic reply(input logic [1:0] code, input int n, input logic [7:0] d0);
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_last  = (i == n);
            rx_data  = (i == 0) ? {6'h0, code} : 8'(d0 + 8'(i - 1));
            if (i > 0) rd_q.push_back(rx_data);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        chk(reply_done == 1'b1, "R7", "reply_done", reply_done, 1);
        chk(busy == 1'b0, "R7", "busy after reply", busy, 0);
        chk(reply_code == code, "R7", "reply_code", reply_code, code);
        if (code != 2'd2) begin
            for (int i = 0; i < pending && m_fifo.size() > 0; i++) void'(m_fifo.pop_front());
        end
        @(negedge clk);
        chk(reply_done == 1'b0, "R7", "reply_done one cycle", reply_done, 0);
        chk(rd_q.size() == 0, "R7", "rd bytes left", rd_q.size(), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R12";
        chk(!busy && !tx_valid && !rd_valid && !reply_done, "R12", "idle outputs",
            {busy, tx_valid, rd_valid, reply_done}, 0);
        chk(reply_code == 2'd0, "R12", "reply_code", reply_code, 0);

        // R10 + R1 + R5: MOT write of four bytes
        cur_req = "R1";
        set_addr(20'h5A3C1);
        push_byte(8'h11); push_byte(8'h22); push_byte(8'h33); push_byte(8'h44);
        issue(4'h4, 1'b0, 4'd3);
        drain();
        reply(2'd0, 0, 8'h00);

        // R2: read, reply carries data
        cur_req = "R2";
        issue(4'h1, 1'b0, 4'd2);
        drain();
        reply(2'd0, 3, 8'hA0);

        // R3: header-only write (MOT) and read
        cur_req = "R3";
        issue(4'h4, 1'b1, 4'd5);
        drain();
        reply(2'd1, 0, 8'h00);
        issue(4'h1, 1'b1, 4'd9);
        drain();
        reply(2'd0, 0, 8'h00);

        // R4 + R5: write status with and without the flag
        cur_req = "R4";
        issue(4'h6, 1'b1, 4'd0);
        drain();
        reply(2'd0, 1, 8'h05);
        issue(4'h2, 1'b0, 4'd7);
        drain();
        reply(2'd0, 0, 8'h00);

        // R6: command while busy is ignored
        cur_req = "R6";
        issue(4'h5, 1'b0, 4'd1);
        reg_write(OFS_CMD, 32'h0000_0000);
        drain();
        reply(2'd0, 2, 8'h30);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0 && exp_q.size() == 0, "R6", "ignored command started a frame",
            busy, 0);

        // R6: unsupported nibbles
        reg_write(OFS_CMD, 32'h0000_0301);
        @(negedge clk);
        chk(busy == 1'b0, "R6", "nibble 0x3 busy", busy, 0);
        reg_write(OFS_CMD, 32'h0000_0900);
        @(negedge clk);
        chk(busy == 1'b0, "R6", "nibble 0x9 busy", busy, 0);

        // R8: DEFER keeps payload, reissue resends it
        cur_req = "R8";
        push_byte(8'h71); push_byte(8'h72);
        issue(4'h0, 1'b0, 4'd1);
        drain();
        reply(2'd2, 0, 8'h00);
        issue(4'h0, 1'b0, 4'd1);
        drain();
        reply(2'd0, 0, 8'h00);
        push_byte(8'h73);
        issue(4'h0, 1'b0, 4'd0);
        drain();
        reply(2'd0, 0, 8'h00);

        // R9: overflow dropped, missing bytes padded
        cur_req = "R9";
        for (int i = 0; i < 17; i++) push_byte(8'(8'h80 + i));
        issue(4'h0, 1'b0, 4'd15);
        drain();
        reply(2'd0, 0, 8'h00);
        issue(4'h0, 1'b0, 4'd0);
        drain();
        reply(2'd0, 0, 8'h00);

        // R10: address change applies to next frame only
        cur_req = "R10";
        set_addr(20'h00012);
        issue(4'h1, 1'b1, 4'd0);
        reg_write(OFS_DADDR, 32'h000F_FFFF);
        drain();
        reply(2'd0, 0, 8'h00);
        m_addr = 20'hFFFFF;
        issue(4'h0, 1'b1, 4'd0);
        drain();
        reply(2'd0, 0, 8'h00);

        // R13: reply bytes while idle
        cur_req = "R13";
        @(negedge clk);
        rx_valid = 1'b1; rx_last = 1'b1; rx_data = 8'h02;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        chk(reply_done == 1'b0 && rd_valid == 1'b0, "R13", "idle reply reaction",
            {reply_done, rd_valid}, 0);
        chk(reply_code == 2'd0, "R13", "reply_code kept", reply_code, 0);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "frame bytes never sent", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule